// File: doc/BRIEF.md
# Tagged serial result shifter

This block drives the serial readout of a 12-bit conversion result. It holds the most recent result word and sends it out one bit at a time, most significant bit first, in two's complement. Two clocking schemes are offered. In internal mode, a conversion start makes the block generate its own data clock by dividing the system clock. It sends the previous result on exactly twelve pulses and then holds the clock low. In external mode, a data clock from outside is synchronised into the system clock domain. Each of its rising edges moves the frame forward while the output is enabled by chip select and the read strobe.

A one-period SYNC marker comes before the first data bit of each external-clock frame. A serial TAG input is sampled along the way. Once the last result bit has left, the captured TAG bits come out of the data line in the order they arrived. Several blocks can therefore be chained on one line. A result update that arrives while the output is enabled and the external clock is high is dropped, and the word being read is kept.

Top module: `serial_tagged_shifter`

## Requirements
- R1: In external mode (`ext_mode_i`=1), `sdata_oe_o` is 1 only while `cs_n_i`=0 and `rd_i`=1. When the output is not enabled, `sdata_o` reads 0, and rising edges of `ext_dclk_i` neither advance the frame nor capture TAG.
- R2: After a result load in external mode, `sync_o` goes high after the first enabled rising edge of `ext_dclk_i` and falls again after the second.
- R3: After the second enabled rising edge of `ext_dclk_i` the result MSB (bit 11) is on `sdata_o`. Each further edge presents the next lower bit, so bit 0 is present after the 13th edge.
- R4: `tag_i` is captured on every enabled external rising edge. After edge 14+j, `sdata_o` shows the TAG value captured at edge j+1, for j = 0, 1, 2, ...
- R5: In internal mode (`ext_mode_i`=0), a `conv_start_i` pulse produces exactly 12 pulses on `dclk_o`. Each pulse is low for HALF_DIV and then high for HALF_DIV system clocks. Afterwards `dclk_o` stays low.
- R6: In internal mode, the bit carried by pulse k (k = 1..12) is result bit 12-k. It is placed on `sdata_o` before the pulse rises and stays until the pulse falls.
- R7: In internal mode, `sdata_oe_o` follows `busy_i`. After the 12th pulse ends, `sdata_o` holds the `tag_i` level sampled when the first pulse rose.
- R8: A pulse on `upd_i` loads `result_i`, except in external mode while the output is enabled and the synchronised external clock is high. In that case the load is discarded and the frame in progress continues with the old word.
- R9: After reset, `sdata_o`, `sdata_oe_o` (with `busy_i`=0 in internal mode), `sync_o` and `dclk_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | 1 = external data clock, 0 = internal generated clock |
| cs_n_i | input | 1 | Chip select, active low |
| rd_i | input | 1 | Read/convert strobe, 1 = read |
| busy_i | input | 1 | Conversion in progress |
| conv_start_i | input | 1 | One-cycle conversion start pulse |
| upd_i | input | 1 | One-cycle result register update pulse |
| result_i | input | W | New conversion result, two's complement |
| tag_i | input | 1 | Serial TAG input for chaining |
| ext_dclk_i | input | 1 | External data clock, asynchronous |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Serial data output enable |
| sync_o | output | 1 | Frame start marker (external mode) |
| dclk_o | output | 1 | Generated data clock (internal mode) |

## Verification
On every cycle, the assertions check these rules: a rejected load leaves the shift word untouched, SYNC drops on the edge after it rose, each data edge moves the previous MSB onto the line, and an internal burst never exceeds twelve rising edges. When a burst ends, they also check that the clock is low and the held TAG level is on the line. Only the bench scenarios can show the full bit order of a frame, with the TAG stream after the LSB. The same holds for the order in which a lost update and a frame in progress interact, and for the output staying quiet when edges arrive with the output disabled.

// File: rtl/sts_pkg.sv
package sts_pkg;

  localparam int unsigned WORD_W = 12;

  // Progress of an external-clock frame since the last result load.
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,   // no enabled edge yet
    FR_SYNC = 2'd1,   // first edge seen, marker active
    FR_DATA = 2'd2    // data (then TAG) streaming
  } frame_e;

  function automatic frame_e frame_next(input frame_e f);
    return (f == FR_IDLE) ? FR_SYNC : FR_DATA;
  endfunction

  // Bit index of the result carried by internal pulse k (1-based).
  function automatic int unsigned pulse_bit(input int unsigned k, input int unsigned n);
    return n - k;
  endfunction

endpackage

// File: rtl/sts_edge_sync.sv
module sts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/sts_int_clkgen.sv
module sts_int_clkgen #(
  parameter int HALF_DIV = 4,
  parameter int NBITS    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic dclk_o,
  output logic ev_bit_o,   // present next bit (start of a low phase)
  output logic ev_tag_o,   // first pulse rises: sample TAG
  output logic ev_done_o   // last pulse falls
);

  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int KW = $clog2(NBITS + 1);

  logic          run_q;
  logic          hi_q;
  logic [PW-1:0] pcnt_q;
  logic [KW-1:0] k_q;
  logic          launch;
  logic          phase_end;

  assign launch    = start_i && !run_q;
  assign phase_end = run_q && (pcnt_q == PW'(HALF_DIV - 1));

  assign ev_bit_o  = launch || (phase_end && hi_q && (k_q != KW'(NBITS)));
  assign ev_tag_o  = phase_end && !hi_q && (k_q == KW'(1));
  assign ev_done_o = phase_end && hi_q && (k_q == KW'(NBITS));
  assign dclk_o    = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hi_q   <= 1'b0;
      pcnt_q <= '0;
      k_q    <= '0;
    end else if (launch) begin
      run_q  <= 1'b1;
      hi_q   <= 1'b0;
      pcnt_q <= '0;
      k_q    <= KW'(1);
    end else if (run_q) begin
      if (phase_end) begin
        pcnt_q <= '0;
        if (!hi_q) begin
          hi_q <= 1'b1;
        end else begin
          hi_q <= 1'b0;
          if (k_q == KW'(NBITS)) run_q <= 1'b0;
          else                   k_q   <= k_q + KW'(1);
        end
      end else begin
        pcnt_q <= pcnt_q + PW'(1);
      end
    end
  end

  // Rising edges seen in the current burst, kept for the budget check.
  logic [KW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen_q <= '0;
    else if (launch)                 seen_q <= '0;
    else if (phase_end && !hi_q)     seen_q <= seen_q + KW'(1);
  end

  p_pulse_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && !hi_q) |-> (seen_q < KW'(NBITS)));

  p_burst_ends_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_o && !start_i) |=> (!dclk_o && !run_q));

endmodule

// File: rtl/sts_shift_core.sv
module sts_shift_core
  import sts_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_mode_i,
  input  logic         rd_en_i,
  input  logic         ext_rise_i,
  input  logic         ext_level_i,
  input  logic         tag_i,
  input  logic         upd_i,
  input  logic [W-1:0] result_i,
  input  logic         ev_bit_i,
  input  logic         ev_tag_i,
  input  logic         ev_done_i,
  output logic         out_bit_o,
  output logic         sync_o,
  output logic         lost_o
);

  frame_e       fr_q;
  logic [W-1:0] sreg_q;
  logic         tag_q;
  logic         out_q;
  logic         ext_step;
  logic         take;

  assign ext_step = ext_mode_i && rd_en_i && ext_rise_i;
  assign lost_o   = upd_i && ext_mode_i && rd_en_i && ext_level_i;
  assign take     = upd_i && !lost_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q   <= FR_IDLE;
      sreg_q <= '0;
      tag_q  <= 1'b0;
      out_q  <= 1'b0;
    end else if (take) begin
      sreg_q <= result_i;
      fr_q   <= FR_IDLE;
      out_q  <= 1'b0;
    end else if (ext_mode_i) begin
      if (ext_step) begin
        tag_q <= tag_i;
        fr_q  <= frame_next(fr_q);
        if (fr_q != FR_IDLE) begin
          out_q  <= sreg_q[W-1];
          sreg_q <= {sreg_q[W-2:0], tag_q};
        end
      end
    end else begin
      if (ev_bit_i) begin
        out_q  <= sreg_q[W-1];
        sreg_q <= {sreg_q[W-2:0], 1'b0};
      end
      if (ev_tag_i)  tag_q <= tag_i;
      if (ev_done_i) out_q <= tag_q;
    end
  end

  assign out_bit_o = out_q;
  assign sync_o    = ext_mode_i && (fr_q == FR_SYNC);

  p_lost_keeps_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !ext_step) |=> ($stable(sreg_q) && $stable(fr_q)));

  p_sync_one_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && ext_step && !upd_i) |=> !sync_o);

  p_msb_to_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_step && (fr_q == FR_DATA) && !upd_i) |=> (out_q == $past(sreg_q[W-1])));

  p_tag_after_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_i && !ext_mode_i && !upd_i) |=> (out_q == $past(tag_q)));

endmodule

// File: rtl/serial_tagged_shifter.sv
module serial_tagged_shifter #(
  parameter int W           = sts_pkg::WORD_W,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_mode_i,
  input  logic         cs_n_i,
  input  logic         rd_i,
  input  logic         busy_i,
  input  logic         conv_start_i,
  input  logic         upd_i,
  input  logic [W-1:0] result_i,
  input  logic         tag_i,
  input  logic         ext_dclk_i,
  output logic         sdata_o,
  output logic         sdata_oe_o,
  output logic         sync_o,
  output logic         dclk_o
);

  logic rd_en;
  logic ext_level, ext_rise;
  logic ev_bit, ev_tag, ev_done;
  logic out_bit;
  logic lost;

  assign rd_en = !cs_n_i && rd_i;

  sts_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_dclk_i),
    .level_o (ext_level),
    .rise_o  (ext_rise)
  );

  sts_int_clkgen #(.HALF_DIV(HALF_DIV), .NBITS(W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (conv_start_i && !ext_mode_i),
    .dclk_o    (dclk_o),
    .ev_bit_o  (ev_bit),
    .ev_tag_o  (ev_tag),
    .ev_done_o (ev_done)
  );

  sts_shift_core #(.W(W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_mode_i  (ext_mode_i),
    .rd_en_i     (rd_en),
    .ext_rise_i  (ext_rise),
    .ext_level_i (ext_level),
    .tag_i       (tag_i),
    .upd_i       (upd_i),
    .result_i    (result_i),
    .ev_bit_i    (ev_bit),
    .ev_tag_i    (ev_tag),
    .ev_done_i   (ev_done),
    .out_bit_o   (out_bit),
    .sync_o      (sync_o),
    .lost_o      (lost)
  );

  assign sdata_oe_o = ext_mode_i ? rd_en : busy_i;
  assign sdata_o    = sdata_oe_o & out_bit;

  p_no_sync_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode_i |-> !sync_o);

  p_lost_only_external_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (ext_mode_i && rd_en));

endmodule

// File: tb/serial_tagged_shifter_tb.sv
module serial_tagged_shifter_tb;

  localparam int W    = 12;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode_i = 1'b1, cs_n_i = 1'b1, rd_i = 1'b0, busy_i = 1'b0;
  logic conv_start_i = 1'b0, upd_i = 1'b0, tag_i = 1'b0, ext_dclk_i = 1'b0;
  logic [W-1:0] result_i = '0;
  logic sdata_o, sdata_oe_o, sync_o, dclk_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_tagged_shifter #(.W(W), .HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i), .cs_n_i(cs_n_i),
    .rd_i(rd_i), .busy_i(busy_i), .conv_start_i(conv_start_i), .upd_i(upd_i),
    .result_i(result_i), .tag_i(tag_i), .ext_dclk_i(ext_dclk_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sync_o(sync_o), .dclk_o(dclk_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected line value after enabled external edge k (k >= 2).
  function automatic logic ext_expect(input logic [W-1:0] w, input logic [31:0] tg, input int k);
    int idx = k - 2;
    if (idx < W) return w[W-1-idx];
    return tg[idx-W];
  endfunction

  task automatic load(input logic [W-1:0] w);
    @(negedge clk); upd_i = 1'b1; result_i = w;
    @(negedge clk); upd_i = 1'b0;
  endtask

  task automatic ext_edge(input logic t);
    @(negedge clk); tag_i = t; ext_dclk_i = 1'b1;
    repeat (4) @(negedge clk);
    ext_dclk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Full external frame; optional lost update while the first edge is high.
  task automatic ext_frame(input logic [W-1:0] w, input bit do_load,
                           input bit lose, input logic [W-1:0] alt);
    logic [31:0] tg = $urandom;
    ext_mode_i = 1'b1;
    if (do_load) load(w);
    cs_n_i = 1'b0; rd_i = 1'b1;
    for (int e = 1; e <= 18; e++) begin
      @(negedge clk); tag_i = tg[e-1]; ext_dclk_i = 1'b1;
      repeat (4) @(negedge clk);
      if (e == 1 && lose) begin
        load(alt);
        chk("R8 frame kept after lost update (sync)", sync_o, 1);
      end
      ext_dclk_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 output enabled", sdata_oe_o, 1);
      if (e == 1) chk("R2 sync after first edge", sync_o, 1);
      if (e == 2) chk("R2 sync falls after second edge", sync_o, 0);
      if (e >= 2 && e <= 13)
        chk(lose ? "R8 old word read out" : "R3 data bit", sdata_o, ext_expect(w, tg, e));
      if (e >= 14) chk("R4 TAG stream", sdata_o, ext_expect(w, tg, e));
    end
  endtask

  task automatic int_frame(input logic [W-1:0] w, input logic first_tag);
    int rises = 0;
    logic prev = 1'b0;
    ext_mode_i = 1'b0; cs_n_i = 1'b1; rd_i = 1'b0;
    load(w);
    @(negedge clk); busy_i = 1'b1; conv_start_i = 1'b1; tag_i = first_tag;
    @(negedge clk); conv_start_i = 1'b0;
    for (int c = 0; c < 2 * HALF * W + 16; c++) begin
      if (dclk_o && !prev) begin
        rises++;
        if (rises <= W) chk("R6 bit on pulse", sdata_o, w[W-rises]);
        tag_i = ~first_tag;
      end
      if (dclk_o && prev) chk("R6 bit stable while high", sdata_o, w[W-rises]);
      prev = dclk_o;
      @(negedge clk);
    end
    chk("R5 pulse count", rises, W);
    chk("R5 clock low after burst", dclk_o, 0);
    chk("R7 TAG held after burst", sdata_o, first_tag);
    chk("R7 oe follows busy high", sdata_oe_o, 1);
    busy_i = 1'b0;
    @(negedge clk);
    chk("R7 oe follows busy low", sdata_oe_o, 0);
    chk("R7 line quiet when busy low", sdata_o, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    ext_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset sdata", sdata_o, 0);
    chk("R9 reset oe", sdata_oe_o, 0);
    chk("R9 reset sync", sync_o, 0);
    chk("R9 reset dclk", dclk_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release dclk", dclk_o, 0);
    chk("R9 after release sync", sync_o, 0);

    // Directed: edges while disabled are ignored (R1).
    ext_mode_i = 1'b1;
    load(12'hA5C);
    cs_n_i = 1'b1; rd_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ext_edge(1'b1);
      chk("R1 disabled oe", sdata_oe_o, 0);
      chk("R1 disabled line", sdata_o, 0);
    end
    cs_n_i = 1'b0; rd_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ext_edge(1'b1);
      chk("R1 read low oe", sdata_oe_o, 0);
      chk("R1 no sync while disabled", sync_o, 0);
    end
    ext_frame(12'hA5C, 1'b0, 1'b0, '0);

    // Directed corner words and the lost update.
    ext_frame(12'h800, 1'b1, 1'b0, '0);
    ext_frame(12'h7FF, 1'b1, 1'b0, '0);
    ext_frame(12'h3C9, 1'b1, 1'b1, 12'hC36);

    // Random external frames.
    for (int i = 0; i < 6; i++) ext_frame(W'($urandom), 1'b1, 1'b0, '0);

    // Internal bursts: directed then random.
    int_frame(12'hFFF, 1'b0);
    int_frame(12'h001, 1'b1);
    for (int i = 0; i < 4; i++) int_frame(W'($urandom), 1'($urandom));

    finish_run();
  end

endmodule